// File: doc/BRIEF.md
# Core Run-State Controller

This block sequences the operating state of a serial peripheral core. Software writes a two-bit code to a state port and reads a three-bit status word back. The status word carries the current state and a valid flag. A change of state is not immediate. The valid flag drops when a request is accepted and rises again once the new state holds. Software must therefore see valid high before it issues a write and again after it.

The core has three states: held-in-reset, paused and running. In the reset state the data path, the FIFOs and the word counters are kept cleared. In the paused state the FIFOs may be loaded but the serial engine stays idle. In the running state the engine executes. A normal transfer goes from reset to run, then to pause, then the FIFOs are preloaded, and then the core returns to run.

A plain write of the reset code is not honoured from the paused state. To leave pause for reset, software writes the clear code twice in a row. A separate soft-reset port forces the core back to reset in one cycle, from any state and at any point of a transition.

Top module: `core_run_ctrl`

## Requirements
- R1: After `rst_n` is released, `stat` reads 3'b100, meaning valid is 1 (bit 2) and the state field is reset (code 0, bits 1:0). `dp_clear` is 1.
- R2: The state codes are reset = 0, run = 1 and pause = 3. A write is accepted when valid is high. An accepted write to run or pause, or a write of reset made from the run or reset state, sends valid low for exactly LAT_CYCLES cycles. Valid then rises in the same cycle as the state field takes the requested code.
- R3: A state write issued while valid is low is ignored. The state field and the moment valid rises do not change.
- R4: In the pause state, a write of code 0 is ignored. Valid stays high and the state stays pause.
- R5: In the pause state, the first write of the clear code (2) only arms the exit and valid stays high. A second clear write that follows with no other state write between them starts a timed transition to reset.
- R6: Any write other than the clear code, accepted after the exit is armed, disarms it. A soft reset also disarms it. After that, the next clear write only arms again.
- R7: A write of the clear code outside the pause state is ignored. Valid stays high and the state does not change.
- R8: A write of 1 on bit 0 of the soft-reset port leaves the core, one cycle later, in reset with valid high. This holds from any state and cancels a transition in progress. A soft-reset write with bit 0 at 0 has no effect. A soft reset wins over a state write made in the same cycle.
- R9: `dp_clear` is high exactly in the reset state. `load_en` is high in the pause and run states. `engine_en` is high only in the run state with valid high, so it drops in the cycle a transition out of run is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| st_wr | input | 1 | State register write strobe |
| st_wdata | input | 2 | Requested state code (0 reset, 1 run, 2 clear, 3 pause) |
| srst_wr | input | 1 | Soft-reset register write strobe |
| srst_wdata | input | 1 | Soft-reset data; 1 forces reset |
| stat | output | 3 | Status word: bit 2 valid, bits 1:0 state |
| dp_clear | output | 1 | Holds the FIFOs, counters and flags cleared |
| load_en | output | 1 | FIFOs may be filled |
| engine_en | output | 1 | Serial engine may run |

## Verification
The bench builds the block with LAT_CYCLES = 3. With that value the bench can sample the flag one cycle before valid rises and again in the cycle it rises, so an off-by-one in the latency counter shows at the ports. Three cycles is also long enough to place a second state write or a soft reset inside a transition window. The pause-exit cases are driven in several orders: arm then clear, arm then another code, and arm then soft reset.

// File: rtl/core_run_pkg.sv
package core_run_pkg;
  localparam logic [1:0] RS_RESET = 2'd0;
  localparam logic [1:0] RS_RUN   = 2'd1;
  localparam logic [1:0] RS_CLEAR = 2'd2;
  localparam logic [1:0] RS_PAUSE = 2'd3;
endpackage

// File: rtl/core_run_decode.sv
// Combinational write decoder: decides whether a state write starts a timed
// transition, which state it targets, and how the pause-exit arm flag moves.
module core_run_decode
  import core_run_pkg::*;
(
  input  logic [1:0] cur_state,
  input  logic       valid,
  input  logic       armed,
  input  logic       wr,
  input  logic [1:0] wdata,
  output logic       start,
  output logic [1:0] tgt,
  output logic       arm_nxt
);
  always_comb begin
    start   = 1'b0;
    tgt     = cur_state;
    arm_nxt = armed;
    if (wr && valid) begin
      arm_nxt = 1'b0;
      if (cur_state == RS_PAUSE) begin
        if (wdata == RS_CLEAR) begin
          if (armed) begin
            start = 1'b1;
            tgt   = RS_RESET;
          end else begin
            arm_nxt = 1'b1;
          end
        end else if (wdata != RS_RESET) begin
          start = 1'b1;
          tgt   = wdata;
        end
      end else if (wdata != RS_CLEAR) begin
        start = 1'b1;
        tgt   = wdata;
      end
    end
  end
endmodule

// File: rtl/core_run_timer.sv
// Transition latency counter: busy for exactly LAT_CYCLES cycles after start.
module core_run_timer #(
  parameter int LAT_CYCLES = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic start,
  output logic busy,
  output logic done
);
  localparam int CW = (LAT_CYCLES > 1) ? $clog2(LAT_CYCLES) : 1;
  localparam logic [CW-1:0] LOAD = CW'(LAT_CYCLES - 1);

  logic          busy_q, busy_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic          cnt_en;

  assign done = busy_q && (cnt_q == '0);
  assign busy = busy_q;

  always_comb begin
    busy_d = busy_q;
    cnt_d  = cnt_q;
    cnt_en = 1'b0;
    if (clr) begin
      busy_d = 1'b0;
    end else if (start) begin
      busy_d = 1'b1;
      cnt_d  = LOAD;
      cnt_en = 1'b1;
    end else if (busy_q) begin
      if (cnt_q == '0) begin
        busy_d = 1'b0;
      end else begin
        cnt_d  = cnt_q - 1'b1;
        cnt_en = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      cnt_q  <= '0;
    end else begin
      busy_q <= busy_d;
      if (cnt_en) cnt_q <= cnt_d;
    end
  end
endmodule

// File: rtl/core_run_ctrl.sv
// Run-state controller: reset / run / pause with a timed valid handshake,
// a two-write clear sequence out of pause and a soft-reset override.
module core_run_ctrl
  import core_run_pkg::*;
#(
  parameter int LAT_CYCLES = 4
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       st_wr,
  input  logic [1:0] st_wdata,
  input  logic       srst_wr,
  input  logic       srst_wdata,
  output logic [2:0] stat,
  output logic       dp_clear,
  output logic       load_en,
  output logic       engine_en
);
  logic [1:0] state_q, state_d;
  logic [1:0] tgt_q, tgt_d;
  logic       armed_q, armed_d;
  logic       srst_hit, busy, done, valid, start, arm_nxt;
  logic [1:0] tgt_w;

  assign srst_hit = srst_wr && srst_wdata;
  assign valid    = !busy;

  core_run_decode u_dec (
    .cur_state (state_q),
    .valid     (valid),
    .armed     (armed_q),
    .wr        (st_wr && !srst_hit),
    .wdata     (st_wdata),
    .start     (start),
    .tgt       (tgt_w),
    .arm_nxt   (arm_nxt)
  );

  core_run_timer #(.LAT_CYCLES(LAT_CYCLES)) u_tmr (
    .clk   (clk),
    .rst_n (rst_n),
    .clr   (srst_hit),
    .start (start),
    .busy  (busy),
    .done  (done)
  );

  always_comb begin
    state_d = state_q;
    tgt_d   = start ? tgt_w : tgt_q;
    armed_d = arm_nxt;
    if (srst_hit) begin
      state_d = RS_RESET;
      armed_d = 1'b0;
    end else if (done) begin
      state_d = tgt_q;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= RS_RESET;
      tgt_q   <= RS_RESET;
      armed_q <= 1'b0;
    end else begin
      state_q <= state_d;
      if (start) tgt_q <= tgt_d;
      armed_q <= armed_d;
    end
  end

  assign stat      = {valid, state_q};
  assign dp_clear  = (state_q == RS_RESET);
  assign load_en   = (state_q == RS_RUN) || (state_q == RS_PAUSE);
  assign engine_en = (state_q == RS_RUN) && valid;
endmodule

// File: rtl/core_run_chk.sv
module core_run_chk
  import core_run_pkg::*;
#(
  parameter int LAT_CYCLES = 4
) (
  input logic       clk,
  input logic       rst_n,
  input logic       st_wr,
  input logic [1:0] st_wdata,
  input logic       srst_wr,
  input logic       srst_wdata,
  input logic [2:0] stat,
  input logic       dp_clear,
  input logic       load_en,
  input logic       engine_en
);
  logic        srst;
  logic [15:0] low_cnt;
  assign srst = srst_wr && srst_wdata;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) low_cnt <= '0;
    else if (stat[2]) low_cnt <= '0;
    else if (low_cnt != 16'hFFFF) low_cnt <= low_cnt + 1'b1;
  end

  // R2: valid low window has the configured length
  p_low_len_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (stat[2] && !$past(stat[2]) && !$past(srst)) |-> (low_cnt == 16'(LAT_CYCLES)));

  // R2: accepted run request from reset drops valid
  p_run_drop_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (stat[2] && stat[1:0] == RS_RESET && st_wr && st_wdata == RS_RUN && !srst)
      |=> !stat[2]);

  // R3: state is frozen while a transition is pending
  p_hold_busy_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!stat[2] && !srst && !$rose(stat[2])) |=> ($stable(stat[1:0]) || stat[2]));

  // R4: reset code ignored in pause
  p_pause_zero_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (stat[2] && stat[1:0] == RS_PAUSE && st_wr && st_wdata == RS_RESET && !srst)
      |=> (stat[2] && stat[1:0] == RS_PAUSE));

  // R7: clear code ignored outside pause
  p_clear_out_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (stat[2] && stat[1:0] != RS_PAUSE && st_wr && st_wdata == RS_CLEAR && !srst)
      |=> (stat[2] && $stable(stat[1:0])));

  // R8: soft reset lands in reset with valid high
  p_srst_r8: assert property (@(posedge clk) disable iff (!rst_n)
    srst |=> (stat == {1'b1, RS_RESET}));

  // R9: engine only runs outside reset with loading allowed
  p_engine_r9: assert property (@(posedge clk) disable iff (!rst_n)
    engine_en |-> (load_en && !dp_clear && stat[2]));

  // R9: reset state gates everything off
  p_reset_gate_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (stat[1:0] == RS_RESET) |-> (dp_clear && !load_en && !engine_en));
endmodule

bind core_run_ctrl core_run_chk #(.LAT_CYCLES(LAT_CYCLES)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .st_wr      (st_wr),
  .st_wdata   (st_wdata),
  .srst_wr    (srst_wr),
  .srst_wdata (srst_wdata),
  .stat       (stat),
  .dp_clear   (dp_clear),
  .load_en    (load_en),
  .engine_en  (engine_en)
);

// File: tb/test_core_run_ctrl.sv
module test_core_run_ctrl;
  localparam int LAT = 3;

  logic       clk, rst_n, st_wr, srst_wr, srst_wdata;
  logic [1:0] st_wdata;
  logic [2:0] stat;
  logic       dp_clear, load_en, engine_en;
  int         n_run, n_fail;

  core_run_ctrl #(.LAT_CYCLES(LAT)) i_core_run_ctrl (
    .clk(clk), .rst_n(rst_n), .st_wr(st_wr), .st_wdata(st_wdata),
    .srst_wr(srst_wr), .srst_wdata(srst_wdata), .stat(stat),
    .dp_clear(dp_clear), .load_en(load_en), .engine_en(engine_en)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  // {code[4:3], expect_busy[2], expect_state[1:0]}
  localparam logic [4:0] VEC [0:14] = '{
    5'b01_1_01, // R2 reset->run
    5'b11_1_11, // R2 run->pause
    5'b00_0_11, // R4 zero ignored in pause
    5'b01_1_01, // R2 pause->run
    5'b11_1_11, // R2 run->pause
    5'b10_0_11, // R5 first clear arms
    5'b10_1_00, // R5 second clear exits
    5'b10_0_00, // R7 clear ignored in reset
    5'b01_1_01, // R2 reset->run
    5'b00_1_00, // R2 run->reset
    5'b11_1_11, // R2 reset->pause
    5'b10_0_11, // R5 arm
    5'b11_1_11, // R6 pause write disarms
    5'b10_0_11, // R6 clear only re-arms
    5'b10_1_00  // R5 exit
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic chk_outs(input string req, input logic [1:0] st);
    chk(req, 32'({dp_clear, load_en}), 32'({st == 2'd0, st != 2'd0}));
    chk(req, 32'(engine_en), 32'(st == 2'd1 && stat[2]));
  endtask

  // called at a negedge
  task automatic wr_state(input string req, input logic [1:0] code,
                          input logic busy_exp, input logic [1:0] st_exp);
    st_wr = 1'b1; st_wdata = code;
    @(negedge clk);
    st_wr = 1'b0;
    chk(req, 32'(stat[2]), 32'(!busy_exp));
    if (busy_exp) begin
      repeat (LAT - 1) @(negedge clk);
      chk(req, 32'(stat[2]), 32'd0);
      @(negedge clk);
    end
    chk(req, 32'(stat), 32'({1'b1, st_exp}));
    chk_outs("R9", stat[1:0]);
  endtask

  task automatic soft_rst(input logic bitv);
    srst_wr = 1'b1; srst_wdata = bitv;
    @(negedge clk);
    srst_wr = 1'b0; srst_wdata = 1'b0;
  endtask

  initial begin
    n_run = 0; n_fail = 0;
    st_wr = 0; st_wdata = 0; srst_wr = 0; srst_wdata = 0; rst_n = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk("R1", 32'(stat), 32'h4);
    chk("R1", 32'(dp_clear), 32'd1);
    chk_outs("R9", stat[1:0]);

    for (int i = 0; i < 15; i++)
      wr_state("R2/R4/R5/R6/R7 vec", VEC[i][4:3], VEC[i][2], VEC[i][1:0]);

    // R3: write while busy ignored, timing unchanged
    st_wr = 1; st_wdata = 2'd1;
    @(negedge clk);
    st_wdata = 2'd3;
    chk("R9", 32'(engine_en), 32'd0);
    @(negedge clk);
    st_wr = 0;
    @(negedge clk);
    chk("R3", 32'(stat[2]), 32'd0);
    @(negedge clk);
    chk("R3", 32'(stat), 32'h5);
    chk("R9", 32'(engine_en), 32'd1);

    // R9: engine drops as soon as run->pause is accepted
    st_wr = 1; st_wdata = 2'd3;
    @(negedge clk);
    st_wr = 0;
    chk("R9", 32'(engine_en), 32'd0);
    chk("R9", 32'(load_en), 32'd1);
    repeat (LAT) @(negedge clk);
    wr_state("R2", 2'd1, 1'b1, 2'd1);

    // R8: soft reset with bit 0 low is ignored
    soft_rst(1'b0);
    chk("R8", 32'(stat), 32'h5);
    soft_rst(1'b1);
    chk("R8", 32'(stat), 32'h4);

    // R8: soft reset cancels pending transition
    st_wr = 1; st_wdata = 2'd1;
    @(negedge clk);
    st_wr = 0;
    soft_rst(1'b1);
    chk("R8", 32'(stat), 32'h4);
    repeat (LAT + 1) @(negedge clk);
    chk("R8", 32'(stat), 32'h4);

    // R8: soft reset wins over same-cycle state write
    st_wr = 1; st_wdata = 2'd1;
    soft_rst(1'b1);
    st_wr = 0;
    chk("R8", 32'(stat), 32'h4);
    repeat (LAT + 1) @(negedge clk);
    chk("R8", 32'(stat), 32'h4);

    // R6/R8: soft reset disarms the pause exit
    wr_state("R2", 2'd3, 1'b1, 2'd3);
    wr_state("R5", 2'd2, 1'b0, 2'd3);
    soft_rst(1'b1);
    chk("R8", 32'(stat), 32'h4);
    wr_state("R2", 2'd3, 1'b1, 2'd3);
    wr_state("R6", 2'd2, 1'b0, 2'd3);
    wr_state("R5", 2'd2, 1'b1, 2'd0);

    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    #1_000_000;
    n_run++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule